// File: doc/BRIEF.md
# Burst Low-Address Sequencer

This block generates the address for each beat of a short burst of memory accesses. A load cycle takes a full external address and starts a new access. Each advance cycle after that steps only the low two address bits, up to four beats, and the count then wraps. The upper bits, the read-or-write type and the selected state are all captured at the load. They stay fixed for every beat of the burst.

A static order input selects how the low bits step. Low selects a linear count modulo four. High selects an exclusive-OR of the start value with the beat count. The chip-select and write-request inputs are looked at only on load cycles. A burst that began deselected therefore stays deselected until the next load.

A clock-enable input stalls the block: while it is low, every register holds. The asynchronous active-low reset is released synchronously inside the block, two clocks after the reset input rises.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, cur_addr is 0, cur_wr is 0 and cur_act is 0.
- R2: A cycle with clk_en=1 and adv=0 is a load. From the next cycle, cur_addr equals ext_addr, cur_wr equals wr_req and cur_act equals sel_ok.
- R3: A cycle with clk_en=1 and adv=1 is an advance. It leaves cur_addr bits above bit 1, cur_wr and cur_act unchanged, whatever wr_req, sel_ok and ext_addr are.
- R4: With order_sel=0, each advance adds one to cur_addr[1:0] modulo 4. A start of 2'b10 gives 10, 11, 00, 01.
- R5: With order_sel=1, beat k of a burst has cur_addr[1:0] equal to the start low bits XOR k. A start of 2'b01 gives 01, 00, 11, 10.
- R6: The fourth advance after a load returns cur_addr[1:0] to the start value in either order.
- R7: A cycle with clk_en=0 changes none of cur_addr, cur_wr or cur_act, whatever the other inputs are, provided order_sel is unchanged.
- R8: A load with sel_ok=0 gives cur_act=0. Advances keep cur_act at 0 even when sel_ok=1. Only a later load with sel_ok=1 sets cur_act back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | 1 = this clock is acted on, 0 = hold every register |
| adv | input | 1 | 1 = advance the burst, 0 = load a new address |
| order_sel | input | 1 | Static order select: 0 = linear, 1 = XOR |
| ext_addr | input | ADDR_W | Address taken on a load |
| wr_req | input | 1 | Access type at load: 1 = write, 0 = read |
| sel_ok | input | 1 | All chip selects active at load |
| cur_addr | output | ADDR_W | Address of the current beat |
| cur_wr | output | 1 | Access type latched at burst start |
| cur_act | output | 1 | Select state latched at burst start |

## Verification
Every result is due one rising edge after the cycle that causes it, because each output comes from a register. The exception is cur_addr, which also follows order_sel directly; the bench keeps order_sel fixed within a burst. The driver sets the inputs on a falling edge and queues the expected outputs at the same moment. The monitor compares them 2 ns after the following rising edge. Stimulus starts only after the two-clock internal reset release, so no queued expectation falls inside it.

// File: rtl/burst_addr_seq_pkg.sv
package burst_addr_seq_pkg;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } order_e;

  typedef struct packed {
    logic wr;
    logic act;
  } acc_t;

endpackage

// File: rtl/burst_addr_seq_rst_sync.sv
module burst_addr_seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];

endmodule

// File: rtl/burst_addr_seq_beat_ctr.sv
module burst_addr_seq_beat_ctr #(
  parameter int LOW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  output logic [LOW_W-1:0] cnt
);

  logic [LOW_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (load)      cnt_d = '0;
    else if (step) cnt_d = cnt + LOW_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load || step)  cnt <= cnt_d;
  end

endmodule

// File: rtl/burst_addr_seq_start_reg.sv
module burst_addr_seq_start_reg #(
  parameter int ADDR_W = 18
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [ADDR_W-1:0]             ext_addr,
  input  logic                          wr_req,
  input  logic                          sel_ok,
  output logic [ADDR_W-1:0]             start_addr,
  output burst_addr_seq_pkg::acc_t      acc
);

  import burst_addr_seq_pkg::*;

  logic [ADDR_W-1:0] start_d;
  acc_t              acc_d;

  always_comb begin
    start_d = start_addr;
    acc_d   = acc;
    if (load) begin
      start_d    = ext_addr;
      acc_d.wr   = wr_req;
      acc_d.act  = sel_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_addr <= '0;
      acc        <= '0;
    end else if (load) begin
      start_addr <= start_d;
      acc        <= acc_d;
    end
  end

endmodule

// File: rtl/burst_addr_seq_low_map.sv
module burst_addr_seq_low_map #(
  parameter int LOW_W = 2
) (
  input  logic             order_sel,
  input  logic [LOW_W-1:0] start_lo,
  input  logic [LOW_W-1:0] cnt,
  output logic [LOW_W-1:0] beat_lo
);

  import burst_addr_seq_pkg::*;

  order_e           ord;
  logic [LOW_W-1:0] lin_lo;
  logic [LOW_W-1:0] xor_lo;

  assign ord    = order_e'(order_sel);
  assign lin_lo = start_lo + cnt;
  assign xor_lo = start_lo ^ cnt;

  always_comb begin
    unique case (ord)
      ORDER_LINEAR: beat_lo = lin_lo;
      ORDER_XOR:    beat_lo = xor_lo;
      default:      beat_lo = lin_lo;
    endcase
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 18,
  parameter int LOW_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              adv,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              wr_req,
  input  logic              sel_ok,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              cur_wr,
  output logic              cur_act
);

  import burst_addr_seq_pkg::*;

  localparam int HI_W = ADDR_W - LOW_W;

  logic              rst_q_n;
  logic              load;
  logic              step;
  logic [LOW_W-1:0]  cnt;
  logic [ADDR_W-1:0] start_addr;
  logic [LOW_W-1:0]  beat_lo;
  acc_t              acc;

  assign load = clk_en & ~adv;
  assign step = clk_en &  adv;

  burst_addr_seq_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  burst_addr_seq_beat_ctr #(.LOW_W(LOW_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_q_n),
    .load  (load),
    .step  (step),
    .cnt   (cnt)
  );

  burst_addr_seq_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .load       (load),
    .ext_addr   (ext_addr),
    .wr_req     (wr_req),
    .sel_ok     (sel_ok),
    .start_addr (start_addr),
    .acc        (acc)
  );

  burst_addr_seq_low_map #(.LOW_W(LOW_W)) u_map (
    .order_sel (order_sel),
    .start_lo  (start_addr[LOW_W-1:0]),
    .cnt       (cnt),
    .beat_lo   (beat_lo)
  );

  assign cur_addr = {start_addr[ADDR_W-1 -: HI_W], beat_lo};
  assign cur_wr   = acc.wr;
  assign cur_act  = acc.act;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 18,
  parameter int LOW_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              adv,
  input logic              order_sel,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              wr_req,
  input logic              sel_ok,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              cur_wr,
  input logic              cur_act
);

  typedef logic [LOW_W-1:0] low_t;

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !adv) |=> (cur_addr == $past(ext_addr)) && (cur_wr == $past(wr_req))
                         && (cur_act == $past(sel_ok)));

  // R3
  advance_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv) |=> (cur_addr[ADDR_W-1:LOW_W] == $past(cur_addr[ADDR_W-1:LOW_W]))
                        && $stable(cur_wr) && $stable(cur_act));

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv && !order_sel) |=>
      (order_sel || cur_addr[LOW_W-1:0] == low_t'($past(cur_addr[LOW_W-1:0]) + 1'b1)));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> (!$stable(order_sel) || $stable(cur_addr)) && $stable(cur_wr) && $stable(cur_act));

  // R8
  deselect_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv && !cur_act) |=> !cur_act);

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .clk_en    (clk_en),
  .adv       (adv),
  .order_sel (order_sel),
  .ext_addr  (ext_addr),
  .wr_req    (wr_req),
  .sel_ok    (sel_ok),
  .cur_addr  (cur_addr),
  .cur_wr    (cur_wr),
  .cur_act   (cur_act)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

  localparam int AW = 18;

  typedef struct {
    logic [AW-1:0] addr;
    logic          wr;
    logic          act;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clk_en;
  logic          adv;
  logic          order_sel;
  logic [AW-1:0] ext_addr;
  logic          wr_req;
  logic          sel_ok;
  logic [AW-1:0] cur_addr;
  logic          cur_wr;
  logic          cur_act;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;
  exp_t exp_q[$];

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_k    = '0;
  logic          m_wr   = 1'b0;
  logic          m_act  = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .adv       (adv),
    .order_sel (order_sel),
    .ext_addr  (ext_addr),
    .wr_req    (wr_req),
    .sel_ok    (sel_ok),
    .cur_addr  (cur_addr),
    .cur_wr    (cur_wr),
    .cur_act   (cur_act)
  );

  // Driver: sets the inputs on a falling edge and queues what the next rising edge must give.
  task automatic drive(input logic en, input logic a, input logic [AW-1:0] ea,
                       input logic w, input logic s, input string tag);
    exp_t e;
    logic [1:0] lo;
    @(negedge clk);
    clk_en = en; adv = a; ext_addr = ea; wr_req = w; sel_ok = s;
    if (en) begin
      if (!a) begin
        m_base = ea; m_k = 2'd0; m_wr = w; m_act = s;
      end else begin
        m_k = m_k + 2'd1;
      end
    end
    lo = order_sel ? (m_base[1:0] ^ m_k) : (m_base[1:0] + m_k);
    e.addr = {m_base[AW-1:2], lo};
    e.wr   = m_wr;
    e.act  = m_act;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compares each queued item 2 ns after the rising edge it belongs to.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (cur_addr !== e.addr || cur_wr !== e.wr || cur_act !== e.act) begin
        errors++;
        $display("FAIL %s: addr=%h wr=%b act=%b expected addr=%h wr=%b act=%b",
                 e.tag, cur_addr, cur_wr, cur_act, e.addr, e.wr, e.act);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clk_en = 1'b0; adv = 1'b0; order_sel = 1'b0;
    ext_addr = '0; wr_req = 1'b0; sel_ok = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    checks++;
    if (cur_addr !== '0 || cur_wr !== 1'b0 || cur_act !== 1'b0) begin
      errors++;
      $display("FAIL R1: addr=%h wr=%b act=%b expected addr=0 wr=0 act=0",
               cur_addr, cur_wr, cur_act);
    end

    // R2 load, R4 linear from 10, R3 advances ignore wr_req/sel_ok/ext_addr, R6 wrap
    order_sel = 1'b0;
    drive(1'b1, 1'b0, 18'h12346, 1'b1, 1'b1, "R2 load write");
    drive(1'b1, 1'b1, 18'h00000, 1'b0, 1'b0, "R4 linear beat1 / R3");
    drive(1'b1, 1'b1, 18'h3FFFF, 1'b0, 1'b0, "R4 linear beat2 / R3");
    drive(1'b1, 1'b1, 18'h15555, 1'b1, 1'b0, "R4 linear beat3");
    drive(1'b1, 1'b1, 18'h00000, 1'b0, 1'b1, "R6 linear wrap");

    // R7 stall with changing inputs
    drive(1'b0, 1'b0, 18'h2AAAA, 1'b0, 1'b0, "R7 stall load ignored");
    drive(1'b0, 1'b1, 18'h11111, 1'b0, 1'b0, "R7 stall advance ignored");
    drive(1'b1, 1'b1, 18'h00000, 1'b0, 1'b0, "R4 linear after stall");

    // R5 XOR order from 01, R6 wrap
    @(negedge clk);
    order_sel = 1'b1;
    drive(1'b1, 1'b0, 18'h0ABC5, 1'b0, 1'b1, "R2 load read");
    drive(1'b1, 1'b1, 18'h00000, 1'b1, 1'b0, "R5 xor beat1");
    drive(1'b1, 1'b1, 18'h00000, 1'b1, 1'b0, "R5 xor beat2");
    drive(1'b1, 1'b1, 18'h00000, 1'b1, 1'b0, "R5 xor beat3");
    drive(1'b1, 1'b1, 18'h00000, 1'b1, 1'b0, "R6 xor wrap");

    // R8 deselected burst stays deselected until a new load
    drive(1'b1, 1'b0, 18'h00402, 1'b1, 1'b0, "R8 load deselected");
    drive(1'b1, 1'b1, 18'h00402, 1'b0, 1'b1, "R8 advance keeps deselect");
    drive(1'b1, 1'b1, 18'h00402, 1'b0, 1'b1, "R8 advance keeps deselect 2");
    drive(1'b1, 1'b0, 18'h00403, 1'b0, 1'b1, "R8 reload selects");
    drive(1'b1, 1'b1, 18'h00000, 1'b0, 1'b0, "R5 xor from 11");

    // Linear from 11 wraps at once
    @(negedge clk);
    order_sel = 1'b0;
    drive(1'b1, 1'b0, 18'h3FFFF, 1'b1, 1'b1, "R2 load top");
    drive(1'b1, 1'b1, 18'h00000, 1'b0, 1'b0, "R4 linear 11 to 00");
    drive(1'b0, 1'b1, 18'h00000, 1'b0, 1'b0, "R7 stall mid burst");
    drive(1'b1, 1'b1, 18'h00000, 1'b0, 1'b0, "R4 linear 00 to 01");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule